// File: doc/BRIEF.md
# Chunked Memory Copy Engine

This block copies a contiguous run of bytes from one memory address to another. A control block hands it a descriptor made of a source address, a destination address, a byte count and a 32-bit configuration word, and pulses a start input. The engine then moves the data in transactions. Each transaction first reads a chunk of bytes into a local buffer of up to 64 bytes, then writes that chunk out. The memory side is a simple byte-wide request/acknowledge port. While the copy runs, the engine exposes its live source pointer, destination pointer and remaining byte count. When the copy ends it reports either done or error.

The chunk size comes from two 4-bit fields of the configuration word: the write size in bits 27:24 and the read size in bits 31:28. A chunk holds 2^min(field, 6) bytes. The last chunk holds whatever bytes remain. If the two fields differ, the engine refuses the copy. Bit 2 of the configuration word asks for the live pointers and count to be put back to their starting values once the copy has ended, so the same descriptor state can be seen again.

The controller has three states. `ST_IDLE` waits for a start. `ST_READ` fetches the bytes of the current chunk. `ST_WRITE` stores them. The named transitions are:
- *accept*: `ST_IDLE` to `ST_READ`, on a start with a nonzero count and equal size fields.
- *refuse_zero*: stays in `ST_IDLE` and sets done.
- *refuse_size*: stays in `ST_IDLE` and sets error.
- *chunk_read*: `ST_READ` to `ST_WRITE`, on the last read acknowledge of a chunk.
- *chunk_next*: `ST_WRITE` to `ST_READ`, on the last write acknowledge of a chunk when bytes remain.
- *finish*: `ST_WRITE` to `ST_IDLE`, on the last write acknowledge of the final chunk.

Top module: `xfer_engine`

## Requirements
- R1: A start with a byte count of zero moves no data and leaves busy low. One cycle after the start, done is high and error is low, and the live pointers and count are unchanged.
- R2: A start whose write size field (cfg bits 27:24) differs from its read size field (cfg bits 31:28) issues no memory request. It leaves busy low and the live values unchanged. One cycle after the start, error is high and done is low. Done and error are never high together.
- R3: The chunk size is 2^min(field, 6) bytes, so no chunk reads or writes more than 64 bytes. Field value 0 gives 1 byte, 2 gives 4, 3 gives 8, and 6 or more gives 64.
- R4: One cycle after an accepted start, busy is high, done and error are low, and the live source, destination and count equal the descriptor values.
- R5: A copy is made of floor(count/size) full chunks followed by one chunk of count mod size bytes when that value is nonzero. Exactly count bytes are read and count bytes written, with no byte written outside the destination range.
- R6: After each chunk's last write acknowledge, the live source and destination rise by the chunk length and the live count falls by the same amount. While busy, the count never increases.
- R7: On normal completion, busy falls and done rises in the same cycle. No memory request is made while busy is low.
- R8: When cfg bit 2 is set, the live count, destination and source hold their starting values after completion.
- R9: Within a chunk, every read completes before the first write of that chunk. The destination ends up holding an exact copy of the source bytes.
- R10: A start that arrives while busy is ignored. The running copy finishes unchanged, and the second descriptor's destination is never written.
- R11: A memory request without acknowledge stays asserted with the same address and direction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle start pulse, sampled with the descriptor |
| src_i | input | ADDR_W | Descriptor source address |
| dst_i | input | ADDR_W | Descriptor destination address |
| count_i | input | CNT_W | Descriptor byte count |
| cfg_i | input | 32 | Configuration word: bit 2 repeat, 27:24 write size, 31:28 read size |
| busy_o | output | 1 | High from the accepted start until completion |
| done_o | output | 1 | Sticky completion flag, cleared on the next start |
| err_o | output | 1 | Sticky size-mismatch flag, cleared on the next start |
| exec_src_o | output | ADDR_W | Live source pointer |
| exec_dst_o | output | ADDR_W | Live destination pointer |
| exec_cnt_o | output | CNT_W | Live remaining byte count |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write (1) or a read (0) |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | 8 | Write data byte |
| mem_ack_i | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata_i | input | 8 | Read data byte |

## Verification
The bound checker watches four things on every cycle:
- the request held stable under back-pressure;
- the absence of requests while idle;
- done and error never being high together;
- the ordering inside each chunk: every write follows all reads, no chunk exceeds 64 bytes, and the count never increases while busy.

The exact chunk lengths, the remainder chunk, the pointer values after a repeat and the byte-exact copy can only be seen in the bench's scenarios. The same holds for an ignored mid-run start and for the flags after a refused start. Those scenarios run against a memory model that stalls acknowledges pseudo-randomly.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } xfer_state_e;

    // configuration word layout; other blocks decode these positions
    localparam int CFG_REPEAT_BIT = 2;
    localparam int CFG_WSZ_LSB    = 24;
    localparam int CFG_RSZ_LSB    = 28;
    localparam int CFG_SZ_W       = 4;

endpackage

// File: rtl/xfer_cfg_decode.sv
module xfer_cfg_decode
    import xfer_pkg::*;
#(
    parameter int MAX_LOG2 = 6,
    localparam int LEN_W   = MAX_LOG2 + 1
) (
    input  logic [CFG_SZ_W-1:0] wsz_i,
    input  logic [CFG_SZ_W-1:0] rsz_i,
    output logic                mismatch_o,
    output logic [LEN_W-1:0]    chunk_o
);

    logic [CFG_SZ_W-1:0] capped;

    always_comb begin
        mismatch_o = (wsz_i != rsz_i);
        capped     = (wsz_i > CFG_SZ_W'(MAX_LOG2)) ? CFG_SZ_W'(MAX_LOG2) : wsz_i;
        chunk_o    = LEN_W'(1) << capped;
    end

endmodule

// File: rtl/xfer_chunk_buf.sv
module xfer_chunk_buf #(
    parameter int MAX_LOG2 = 6,
    localparam int DEPTH   = 1 << MAX_LOG2
) (
    input  logic                clk,
    input  logic                wr_en_i,
    input  logic [MAX_LOG2-1:0] wr_idx_i,
    input  logic [7:0]          wr_data_i,
    input  logic [MAX_LOG2-1:0] rd_idx_i,
    output logic [7:0]          rd_data_o
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            store[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = store[rd_idx_i];

endmodule

// File: rtl/xfer_exec_regs.sv
module xfer_exec_regs #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32,
    parameter int MAX_LOG2 = 6,
    localparam int LEN_W   = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              restore_i,
    input  logic              advance_i,
    input  logic [ADDR_W-1:0] ld_src_i,
    input  logic [ADDR_W-1:0] ld_dst_i,
    input  logic [CNT_W-1:0]  ld_cnt_i,
    input  logic [LEN_W-1:0]  step_i,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o
);

    logic [ADDR_W-1:0] base_src, base_dst;
    logic [CNT_W-1:0]  base_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_o    <= '0;
            dst_o    <= '0;
            cnt_o    <= '0;
            base_src <= '0;
            base_dst <= '0;
            base_cnt <= '0;
        end else if (load_i) begin
            src_o    <= ld_src_i;
            dst_o    <= ld_dst_i;
            cnt_o    <= ld_cnt_i;
            base_src <= ld_src_i;
            base_dst <= ld_dst_i;
            base_cnt <= ld_cnt_i;
        end else if (restore_i) begin
            src_o <= base_src;
            dst_o <= base_dst;
            cnt_o <= base_cnt;
        end else if (advance_i) begin
            src_o <= src_o + ADDR_W'(step_i);
            dst_o <= dst_o + ADDR_W'(step_i);
            cnt_o <= cnt_o - CNT_W'(step_i);
        end
    end

endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xfer_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32,
    parameter int MAX_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [31:0]       cfg_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] exec_src_o,
    output logic [ADDR_W-1:0] exec_dst_o,
    output logic [CNT_W-1:0]  exec_cnt_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [7:0]        mem_rdata_i
);

    localparam int LEN_W = MAX_LOG2 + 1;

    xfer_state_e state, state_nx;

    logic [LEN_W-1:0] idx_q, len_q, chunk_q;
    logic             rpt_q, done_q, err_q;

    logic [LEN_W-1:0] chunk_sz, first_len, next_len;
    logic [CNT_W-1:0] rem_after;
    logic             size_bad, accept, last_byte, last_chunk;
    logic             exec_load, exec_adv, exec_rst;
    logic             buf_we;
    logic [7:0]       buf_rd;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_i[CFG_WSZ_LSB-1:CFG_REPEAT_BIT+1], cfg_i[CFG_REPEAT_BIT-1:0]};

    xfer_cfg_decode #(.MAX_LOG2(MAX_LOG2)) u_dec (
        .wsz_i      (cfg_i[CFG_WSZ_LSB +: CFG_SZ_W]),
        .rsz_i      (cfg_i[CFG_RSZ_LSB +: CFG_SZ_W]),
        .mismatch_o (size_bad),
        .chunk_o    (chunk_sz)
    );

    xfer_chunk_buf #(.MAX_LOG2(MAX_LOG2)) u_buf (
        .clk       (clk),
        .wr_en_i   (buf_we),
        .wr_idx_i  (idx_q[MAX_LOG2-1:0]),
        .wr_data_i (mem_rdata_i),
        .rd_idx_i  (idx_q[MAX_LOG2-1:0]),
        .rd_data_o (buf_rd)
    );

    xfer_exec_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LOG2(MAX_LOG2)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (exec_load),
        .restore_i (exec_rst),
        .advance_i (exec_adv),
        .ld_src_i  (src_i),
        .ld_dst_i  (dst_i),
        .ld_cnt_i  (count_i),
        .step_i    (len_q),
        .src_o     (exec_src_o),
        .dst_o     (exec_dst_o),
        .cnt_o     (exec_cnt_o)
    );

    // chunk length arithmetic
    always_comb begin
        first_len  = (count_i >= CNT_W'(chunk_sz)) ? chunk_sz : count_i[LEN_W-1:0];
        rem_after  = exec_cnt_o - CNT_W'(len_q);
        next_len   = (rem_after >= CNT_W'(chunk_q)) ? chunk_q : rem_after[LEN_W-1:0];
        last_byte  = (idx_q == len_q - LEN_W'(1));
        last_chunk = (exec_cnt_o == CNT_W'(len_q));
        accept     = (state == ST_IDLE) && start_i && (count_i != '0) && !size_bad;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = ST_READ;                  // accept
            end
            ST_READ: begin
                if (mem_ack_i && last_byte) state_nx = ST_WRITE; // chunk_read
            end
            ST_WRITE: begin
                if (mem_ack_i && last_byte) begin
                    state_nx = last_chunk ? ST_IDLE : ST_READ;   // finish / chunk_next
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (state != ST_IDLE);
        mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
        mem_we_o    = (state == ST_WRITE);
        mem_addr_o  = ((state == ST_WRITE) ? exec_dst_o : exec_src_o) + ADDR_W'(idx_q);
        mem_wdata_o = buf_rd;
        done_o      = done_q;
        err_o       = err_q;
        buf_we      = (state == ST_READ) && mem_ack_i;
        exec_load   = accept;
        exec_adv    = (state == ST_WRITE) && mem_ack_i && last_byte;
        exec_rst    = exec_adv && last_chunk && rpt_q;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            len_q   <= '0;
            chunk_q <= '0;
            rpt_q   <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        if (count_i == '0) begin             // refuse_zero
                            done_q <= 1'b1;
                            err_q  <= 1'b0;
                        end else if (size_bad) begin         // refuse_size
                            done_q <= 1'b0;
                            err_q  <= 1'b1;
                        end else begin                       // accept
                            done_q  <= 1'b0;
                            err_q   <= 1'b0;
                            idx_q   <= '0;
                            len_q   <= first_len;
                            chunk_q <= chunk_sz;
                            rpt_q   <= cfg_i[CFG_REPEAT_BIT];
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack_i) begin
                        idx_q <= last_byte ? '0 : idx_q + LEN_W'(1);
                    end
                end
                ST_WRITE: begin
                    if (mem_ack_i) begin
                        if (last_byte) begin
                            idx_q <= '0;
                            if (last_chunk) begin
                                done_q <= 1'b1;
                            end else begin
                                len_q <= next_len;
                            end
                        end else begin
                            idx_q <= idx_q + LEN_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 32,
    parameter int MAX_LOG2 = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o,
    input logic [CNT_W-1:0]  exec_cnt_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ack_i
);

    localparam int CW = MAX_LOG2 + 2;

    logic [CW-1:0] rds, wrs;

    // per-chunk tally of read and write acknowledges
    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o) begin
            rds <= '0;
            wrs <= '0;
        end else if (mem_req_o && mem_ack_i) begin
            if (!mem_we_o) begin
                rds <= rds + CW'(1);
            end else if (wrs + CW'(1) == rds) begin
                rds <= '0;
                wrs <= '0;
            end else begin
                wrs <= wrs + CW'(1);
            end
        end
    end

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    assert_read_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && !mem_we_o) |-> (wrs == '0));

    assert_write_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i && mem_we_o) |-> (wrs < rds));

    assert_chunk_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rds <= CW'(1 << MAX_LOG2));

    assert_cnt_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (exec_cnt_o <= $past(exec_cnt_o)));

endmodule

bind xfer_engine xfer_engine_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_LOG2(MAX_LOG2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .exec_cnt_o (exec_cnt_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i)
);

// File: tb/xfer_engine_tb.sv
`timescale 1ns/1ps
module xfer_engine_tb;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] cnt;
        logic [3:0]  wsz;
        logic [3:0]  rsz;
        logic        rpt;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h010, 32'h200, 32'd16,  4'd2, 4'd2, 1'b0},
        '{32'h021, 32'h240, 32'd10,  4'd3, 4'd3, 1'b0},
        '{32'h003, 32'h280, 32'd100, 4'd9, 4'd9, 1'b0},
        '{32'h050, 32'h210, 32'd5,   4'd0, 4'd0, 1'b1},
        '{32'h0F0, 32'h2F0, 32'd3,   4'd6, 4'd6, 1'b0},
        '{32'h000, 32'h300, 32'd0,   4'd2, 4'd2, 1'b0},
        '{32'h000, 32'h300, 32'd8,   4'd2, 4'd3, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src = '0, dst = '0, cnt = '0, cfg = '0;
    logic        busy, done, err;
    logic [31:0] exec_src, exec_dst, exec_cnt;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .src_i(src), .dst_i(dst),
        .count_i(cnt), .cfg_i(cfg), .busy_o(busy), .done_o(done), .err_o(err),
        .exec_src_o(exec_src), .exec_dst_o(exec_dst), .exec_cnt_o(exec_cnt),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
    );

    // memory model with pseudo-random stalls
    logic [7:0] mem [1024];
    logic [7:0] lfsr = 8'hA5;
    int rd_acks = 0, wr_acks = 0;

    assign mem_ack   = mem_req && !(lfsr[0] && lfsr[2]);
    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[9:0]] <= mem_wdata;
                wr_acks <= wr_acks + 1;
            end else begin
                rd_acks <= rd_acks + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem(input int seed);
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 13 + seed + 1);
        for (int i = 512; i < 1024; i++) mem[i] = 8'h00;
    endtask

    // drive a descriptor at a negedge and pulse start for one cycle
    task automatic pulse(input vec_t v);
        src   = v.src;
        dst   = v.dst;
        cnt   = v.cnt;
        cfg   = {v.rsz, v.wsz, 21'd0, v.rpt, 2'b00};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int seed);
        logic [31:0] o_src, o_dst, o_cnt, prev, chunk, expstep, steps, nch;
        int r0, w0, guard;
        bit ok;
        fill_mem(seed);
        @(negedge clk);
        o_src = exec_src; o_dst = exec_dst; o_cnt = exec_cnt;
        r0 = rd_acks; w0 = wr_acks;
        chunk = 32'd1 << ((v.wsz > 4'd6) ? 4'd6 : v.wsz);
        pulse(v);
        if (v.cnt == 0) begin
            chk(!busy && done && !err, "R1 flags", {busy, done, err}, 3'b010);
            chk(exec_src == o_src && exec_dst == o_dst && exec_cnt == o_cnt, "R1 exec", exec_cnt, o_cnt);
            repeat (4) @(negedge clk);
            chk(rd_acks == r0 && wr_acks == w0, "R1 no traffic", rd_acks - r0, 0);
        end else if (v.wsz != v.rsz) begin
            chk(!busy && !done && err, "R2 flags", {busy, done, err}, 3'b001);
            chk(exec_src == o_src && exec_dst == o_dst && exec_cnt == o_cnt, "R2 exec", exec_src, o_src);
            repeat (4) @(negedge clk);
            chk(rd_acks == r0 && wr_acks == w0, "R2 no traffic", wr_acks - w0, 0);
        end else begin
            chk(busy && !done && !err, "R4 flags", {busy, done, err}, 3'b100);
            chk(exec_src == v.src && exec_dst == v.dst && exec_cnt == v.cnt, "R4 load", exec_cnt, v.cnt);
            prev = v.cnt; steps = 0; ok = 1; guard = 0;
            while (busy && guard < 20000) begin
                @(negedge clk);
                guard++;
                if (exec_cnt != prev && !(!busy && v.rpt)) begin
                    expstep = (prev < chunk) ? prev : chunk;
                    if (prev - exec_cnt != expstep) begin
                        ok = 0;
                        chk(0, "R3 chunk step", prev - exec_cnt, expstep);
                    end
                    steps++;
                    prev = exec_cnt;
                end
            end
            if (v.rpt) steps++;
            nch = v.cnt / chunk + ((v.cnt % chunk) != 0 ? 1 : 0);
            chk(ok && steps == nch, "R5 chunk count", steps, nch);
            chk(!busy && done && !err, "R7 completion", {busy, done, err}, 3'b010);
            if (v.rpt)
                chk(exec_src == v.src && exec_dst == v.dst && exec_cnt == v.cnt, "R8 restore", exec_cnt, v.cnt);
            else
                chk(exec_src == v.src + v.cnt && exec_dst == v.dst + v.cnt && exec_cnt == 0,
                    "R6 final pointers", exec_dst, v.dst + v.cnt);
            chk(rd_acks - r0 == int'(v.cnt) && wr_acks - w0 == int'(v.cnt), "R5 byte totals",
                wr_acks - w0, v.cnt);
            ok = 1;
            for (int i = 0; i < int'(v.cnt); i++)
                if (mem[v.dst[9:0] + 10'(i)] != mem[v.src[9:0] + 10'(i)]) ok = 0;
            chk(ok, "R9 copy data", ok, 1);
            chk(mem[v.dst[9:0] + v.cnt[9:0]] == 8'h00, "R5 no overrun", mem[v.dst[9:0] + v.cnt[9:0]], 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        fill_mem(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !mem_req, "R7 reset flags", {busy, done, err, mem_req}, 0);
        chk(exec_src == 0 && exec_dst == 0 && exec_cnt == 0, "R4 reset exec", exec_cnt, 0);

        for (int k = 0; k < NVEC; k++) run_vec(VECS[k], k);

        // R10: start while busy is ignored
        begin
            int guard;
            fill_mem(9);
            pulse('{32'h000, 32'h200, 32'd40, 4'd2, 4'd2, 1'b0});
            repeat (10) @(negedge clk);
            chk(busy, "R10 still busy", busy, 1);
            pulse('{32'h100, 32'h300, 32'd8, 4'd2, 4'd2, 1'b0});
            guard = 0;
            while (busy && guard < 20000) begin @(negedge clk); guard++; end
            chk(exec_src == 32'd40 && exec_dst == 32'h228, "R10 first run intact", exec_dst, 32'h228);
            chk(mem[10'h300] == 0 && mem[10'h307] == 0, "R10 second dest untouched", mem[10'h300], 0);
            repeat (3) @(negedge clk);
            chk(!busy && done, "R10 stays idle", busy, 0);
        end

        // R4: flags cleared by next start
        pulse('{32'h000, 32'h300, 32'd4, 4'd1, 4'd2, 1'b0});
        chk(!done && err, "R4 done cleared by start", done, 0);
        pulse('{32'h000, 32'h300, 32'd4, 4'd1, 4'd1, 1'b0});
        chk(busy && !err && !done, "R4 err cleared by start", err, 0);
        begin
            int guard = 0;
            while (busy && guard < 20000) begin @(negedge clk); guard++; end
        end
        chk(done && exec_cnt == 0, "R7 second completion", exec_cnt, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule